// File: doc/BRIEF.md
# Double-Data-Rate Input Capture Register

This block takes a serial data input that changes twice per clock period and splits it into two single-rate outputs. The sample taken at the rising clock edge goes to `q1` and the sample taken at the falling edge goes to `q2`. The data path is `WIDTH` bits wide, one independent lane per bit. The block sits directly behind an input pin, so its inputs are plain. A new sample arrives every half period and cannot be stalled, so there is no valid/ready handshake and no back-pressure. A downstream consumer must take each pair in the clock period in which it is presented.

The `ALIGN` parameter sets how the pair lines up with the rising edge:
- **Opposite-edge:** each output changes on its own edge.
- **Same-edge:** both outputs change on the rising edge. `q2` then carries the falling sample of the previous half period.
- **Same-edge pipelined:** the rising sample is held for one more rising edge, so `q1` and `q2` always come from the same clock period.

A clock enable freezes every stage. The set/reset input loads each output with its own initial value. `SR_KIND` makes that input either asynchronous or sampled on the clock edges.

Top module: `ddr_in_capture`

## Requirements
- R1: In opposite-edge and same-edge modes, with `ce` high and `sr` low, the value on `din` just before a rising edge appears on `q1` just after that edge.
- R2: In opposite-edge mode, with `ce` high and `sr` low, the value on `din` just before a falling edge appears on `q2` just after that falling edge.
- R3: In same-edge mode, `q2` changes only at rising edges. After rising edge n+1 it holds the sample taken at the falling edge between rising edges n and n+1.
- R4: In same-edge pipelined mode, after rising edge n+1, `q1` holds the sample from rising edge n and `q2` holds the sample from the falling edge that follows rising edge n.
- R5: While `ce` is low, no stage captures data at either edge, so `q1` and `q2` keep their values. When `ce` returns high, capture resumes from the held state.
- R6: While `sr` is held high across clock edges, every bit of `q1` equals parameter `Q1_INIT` and every bit of `q2` equals parameter `Q2_INIT` (each 0 or 1, default 0).
- R7: With `SR_KIND` asynchronous, raising `sr` forces both outputs and all internal stages to their initial values at once, without waiting for a clock edge.
- R8: With `SR_KIND` synchronous, `sr` acts only when it is high at a clock edge: rising-edge stages reset at a rising edge and the falling-edge stage at a falling edge. A pulse between edges has no effect.
- R9: `sr` takes priority over `ce`: a reset while `ce` is low still loads the initial values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; both edges are used |
| ce | input | 1 | Clock enable for all stages, active high |
| sr | input | 1 | Set/reset to initial values, active high; type set by `SR_KIND` |
| din | input | WIDTH | Double-rate serial data input |
| q1 | output | WIDTH | Rising-edge sample, aligned per `ALIGN` |
| q2 | output | WIDTH | Falling-edge sample, aligned per `ALIGN` |

## Verification
The hardest cases to reach from the ports are the resets that fall between clock edges:
- an asynchronous pulse that starts and ends inside one half period;
- a synchronous pulse that spans exactly one rising edge but no falling edge.

Only these separate the two reset types, and only they show the falling-edge stage being left alone. The bench places `sr` with sub-half-period delays, measured from a falling edge. Four instances run side by side on the same stimulus, one per alignment mode plus one synchronous-reset instance. A single pulse therefore shows asynchronous instances collapsing to their initial values while the synchronous one stays untouched.

// File: rtl/ddr_in_pkg.sv
`timescale 1ns/1ps
package ddr_in_pkg;

  // Output alignment relative to the rising edge
  typedef enum logic [1:0] {
    ALIGN_OPPOSITE  = 2'd0,
    ALIGN_SAME      = 2'd1,
    ALIGN_SAME_PIPE = 2'd2
  } align_e;

  // Set/reset flavour
  typedef enum logic {
    SR_ASYNC = 1'b0,
    SR_SYNC  = 1'b1
  } sr_kind_e;

endpackage

// File: rtl/ddr_edge_flop.sv
`timescale 1ns/1ps
// Single capture stage: chosen edge, clock enable, set/reset to INIT.
module ddr_edge_flop #(
  parameter int                  WIDTH   = 1,
  parameter bit                  FALLING = 1'b0,
  parameter ddr_in_pkg::sr_kind_e SR_KIND = ddr_in_pkg::SR_ASYNC,
  parameter logic [WIDTH-1:0]    INIT    = '0
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             sr,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam bit IS_ASYNC = (SR_KIND == ddr_in_pkg::SR_ASYNC);

  generate
    if (!FALLING && IS_ASYNC) begin : g_rise_async
      always_ff @(posedge clk or posedge sr) begin
        if (sr)      q <= INIT;
        else if (ce) q <= d;
      end
    end else if (!FALLING) begin : g_rise_sync
      always_ff @(posedge clk) begin
        if (sr)      q <= INIT;
        else if (ce) q <= d;
      end
    end else if (IS_ASYNC) begin : g_fall_async
      always_ff @(negedge clk or posedge sr) begin
        if (sr)      q <= INIT;
        else if (ce) q <= d;
      end
    end else begin : g_fall_sync
      always_ff @(negedge clk) begin
        if (sr)      q <= INIT;
        else if (ce) q <= d;
      end
    end
  endgenerate

endmodule

// File: rtl/ddr_realign.sv
`timescale 1ns/1ps
// Moves the falling-edge sample (and, when pipelined, the rising one)
// onto the rising edge so that both outputs change together.
module ddr_realign #(
  parameter int                  WIDTH   = 1,
  parameter bit                  PIPE    = 1'b0,
  parameter ddr_in_pkg::sr_kind_e SR_KIND = ddr_in_pkg::SR_ASYNC,
  parameter logic [WIDTH-1:0]    Q1_INIT = '0,
  parameter logic [WIDTH-1:0]    Q2_INIT = '0
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             sr,
  input  logic [WIDTH-1:0] rise_q,
  input  logic [WIDTH-1:0] fall_q,
  output logic [WIDTH-1:0] q1,
  output logic [WIDTH-1:0] q2
);

  // Falling sample retimed to the next rising edge
  ddr_edge_flop #(
    .WIDTH(WIDTH), .FALLING(1'b0), .SR_KIND(SR_KIND), .INIT(Q2_INIT)
  ) u_fall_retime (
    .clk(clk), .ce(ce), .sr(sr), .d(fall_q), .q(q2)
  );

  generate
    if (PIPE) begin : g_pipe
      // Rising sample held one more rising edge to pair with its falling mate
      ddr_edge_flop #(
        .WIDTH(WIDTH), .FALLING(1'b0), .SR_KIND(SR_KIND), .INIT(Q1_INIT)
      ) u_rise_delay (
        .clk(clk), .ce(ce), .sr(sr), .d(rise_q), .q(q1)
      );
    end else begin : g_direct
      assign q1 = rise_q;
    end
  endgenerate

endmodule

// File: rtl/ddr_in_capture.sv
`timescale 1ns/1ps
module ddr_in_capture #(
  parameter int                  WIDTH   = 1,
  parameter ddr_in_pkg::align_e  ALIGN   = ddr_in_pkg::ALIGN_OPPOSITE,
  parameter ddr_in_pkg::sr_kind_e SR_KIND = ddr_in_pkg::SR_ASYNC,
  parameter bit                  Q1_INIT = 1'b0,
  parameter bit                  Q2_INIT = 1'b0
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             sr,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q1,
  output logic [WIDTH-1:0] q2
);

  localparam logic [WIDTH-1:0] Q1_VEC = {WIDTH{Q1_INIT}};
  localparam logic [WIDTH-1:0] Q2_VEC = {WIDTH{Q2_INIT}};
  localparam bit RETIME = (ALIGN != ddr_in_pkg::ALIGN_OPPOSITE);
  localparam bit PIPE   = (ALIGN == ddr_in_pkg::ALIGN_SAME_PIPE);

  logic [WIDTH-1:0] rise_q;
  logic [WIDTH-1:0] fall_q;

  ddr_edge_flop #(
    .WIDTH(WIDTH), .FALLING(1'b0), .SR_KIND(SR_KIND), .INIT(Q1_VEC)
  ) u_rise (
    .clk(clk), .ce(ce), .sr(sr), .d(din), .q(rise_q)
  );

  ddr_edge_flop #(
    .WIDTH(WIDTH), .FALLING(1'b1), .SR_KIND(SR_KIND), .INIT(Q2_VEC)
  ) u_fall (
    .clk(clk), .ce(ce), .sr(sr), .d(din), .q(fall_q)
  );

  generate
    if (RETIME) begin : g_retime
      ddr_realign #(
        .WIDTH(WIDTH), .PIPE(PIPE), .SR_KIND(SR_KIND),
        .Q1_INIT(Q1_VEC), .Q2_INIT(Q2_VEC)
      ) u_align (
        .clk(clk), .ce(ce), .sr(sr),
        .rise_q(rise_q), .fall_q(fall_q),
        .q1(q1), .q2(q2)
      );
    end else begin : g_opposite
      assign q1 = rise_q;
      assign q2 = fall_q;
    end
  endgenerate

endmodule

// File: rtl/ddr_in_capture_chk.sv
`timescale 1ns/1ps
module ddr_in_capture_chk #(
  parameter int                  WIDTH   = 1,
  parameter ddr_in_pkg::align_e  ALIGN   = ddr_in_pkg::ALIGN_OPPOSITE,
  parameter ddr_in_pkg::sr_kind_e SR_KIND = ddr_in_pkg::SR_ASYNC,
  parameter bit                  Q1_INIT = 1'b0,
  parameter bit                  Q2_INIT = 1'b0
) (
  input logic             clk,
  input logic             ce,
  input logic             sr,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] rise_q,
  input logic [WIDTH-1:0] fall_q,
  input logic [WIDTH-1:0] q1,
  input logic [WIDTH-1:0] q2
);

  localparam logic [WIDTH-1:0] Q1_VEC = {WIDTH{Q1_INIT}};
  localparam logic [WIDTH-1:0] Q2_VEC = {WIDTH{Q2_INIT}};

  bit started = 1'b0;
  bit sr_seen = 1'b0;    // sr was high at some point since the last rising edge
  bit sr_seen_n = 1'b0;  // same, relative to the last falling edge

  always_ff @(posedge clk) started <= 1'b1;

  always_ff @(posedge clk or posedge sr) begin
    if (sr) sr_seen <= 1'b1;
    else    sr_seen <= 1'b0;
  end

  always_ff @(negedge clk or posedge sr) begin
    if (sr) sr_seen_n <= 1'b1;
    else    sr_seen_n <= 1'b0;
  end

  AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (sr || !started)
    (ce && !sr_seen) |=> (rise_q == $past(din) || sr_seen)); // R1

  AST_CE_HOLD: assert property (@(posedge clk) disable iff (sr || !started)
    (!ce && !sr_seen) |=> ($stable(q1) || sr_seen)); // R5

  generate
    if (ALIGN == ddr_in_pkg::ALIGN_OPPOSITE) begin : g_opp
      AST_FALL_CAPTURE: assert property (@(negedge clk) disable iff (sr || !started)
        (ce && !sr_seen_n) |=> (fall_q == $past(din) || sr_seen_n)); // R2
    end else begin : g_same
      AST_Q2_FROM_FALL: assert property (@(posedge clk) disable iff (sr || !started)
        (ce && !sr_seen) |=> (q2 == $past(fall_q) || sr_seen)); // R3
      AST_Q2_HOLD: assert property (@(posedge clk) disable iff (sr || !started)
        (!ce && !sr_seen) |=> ($stable(q2) || sr_seen)); // R5
    end

    if (ALIGN == ddr_in_pkg::ALIGN_SAME_PIPE) begin : g_pipe
      AST_Q1_PIPELINED: assert property (@(posedge clk) disable iff (sr || !started)
        (ce && !sr_seen) |=> (q1 == $past(rise_q) || sr_seen)); // R4
    end

    if (SR_KIND == ddr_in_pkg::SR_ASYNC) begin : g_async
      AST_ASYNC_INIT: assert property (@(posedge clk) disable iff (!started)
        sr |-> (q1 == Q1_VEC && q2 == Q2_VEC)); // R7
    end else begin : g_sync
      AST_SYNC_INIT: assert property (@(posedge clk) disable iff (!started)
        sr |=> (q1 == Q1_VEC)); // R8
    end
  endgenerate

endmodule

bind ddr_in_capture ddr_in_capture_chk #(
  .WIDTH(WIDTH), .ALIGN(ALIGN), .SR_KIND(SR_KIND),
  .Q1_INIT(Q1_INIT), .Q2_INIT(Q2_INIT)
) u_chk (
  .clk(clk), .ce(ce), .sr(sr), .din(din),
  .rise_q(rise_q), .fall_q(fall_q), .q1(q1), .q2(q2)
);

// File: tb/ddr_in_capture_test.sv
`timescale 1ns/1ps
module ddr_in_capture_test;

  logic clk = 1'b0;
  logic ce  = 1'b0;
  logic sr  = 1'b1;
  logic din = 1'b0;

  logic o_q1, o_q2, s_q1, s_q2, p_q1, p_q2, y_q1, y_q2;

  int checks = 0;
  int errors = 0;

  // Reference state for the retimed instances
  logic same_pb;
  logic pipe_pa, pipe_pb;
  logic sync_pa, sync_pb;

  always #2 clk = ~clk;  // 250 MHz

  // Opposite-edge, asynchronous, inits 0/0
  ddr_in_capture #(.WIDTH(1), .ALIGN(ddr_in_pkg::ALIGN_OPPOSITE),
    .SR_KIND(ddr_in_pkg::SR_ASYNC), .Q1_INIT(1'b0), .Q2_INIT(1'b0))
    uut (.clk(clk), .ce(ce), .sr(sr), .din(din), .q1(o_q1), .q2(o_q2));

  // Same-edge, asynchronous, inits 1/0
  ddr_in_capture #(.WIDTH(1), .ALIGN(ddr_in_pkg::ALIGN_SAME),
    .SR_KIND(ddr_in_pkg::SR_ASYNC), .Q1_INIT(1'b1), .Q2_INIT(1'b0))
    u_same (.clk(clk), .ce(ce), .sr(sr), .din(din), .q1(s_q1), .q2(s_q2));

  // Pipelined, asynchronous, inits 0/1
  ddr_in_capture #(.WIDTH(1), .ALIGN(ddr_in_pkg::ALIGN_SAME_PIPE),
    .SR_KIND(ddr_in_pkg::SR_ASYNC), .Q1_INIT(1'b0), .Q2_INIT(1'b1))
    u_pipe (.clk(clk), .ce(ce), .sr(sr), .din(din), .q1(p_q1), .q2(p_q2));

  // Pipelined, synchronous, inits 1/1
  ddr_in_capture #(.WIDTH(1), .ALIGN(ddr_in_pkg::ALIGN_SAME_PIPE),
    .SR_KIND(ddr_in_pkg::SR_SYNC), .Q1_INIT(1'b1), .Q2_INIT(1'b1))
    u_sync (.clk(clk), .ce(ce), .sr(sr), .din(din), .q1(y_q1), .q2(y_q2));

  task automatic check(input string tag, input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
    end
  endtask

  // Starts just after a falling edge; returns just after the next falling edge.
  task automatic run_cycle(input logic a, input logic b);
    din = a;
    @(posedge clk); #1 din = b;
    @(negedge clk); #1;
    check("R1", "uut.q1", o_q1, a);
    check("R2", "uut.q2", o_q2, b);
    check("R1", "same.q1", s_q1, a);
    check("R3", "same.q2", s_q2, same_pb);
    check("R4", "pipe.q1", p_q1, pipe_pa);
    check("R4", "pipe.q2", p_q2, pipe_pb);
    check("R4", "sync.q1", y_q1, sync_pa);
    check("R4", "sync.q2", y_q2, sync_pb);
    same_pb = b;
    pipe_pa = a; pipe_pb = b;
    sync_pa = a; sync_pb = b;
  endtask

  task automatic t_reset_state();
    // sr high with ce low for three periods: R6 and R9
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R6", "uut.q1 init", o_q1, 1'b0);
    check("R6", "uut.q2 init", o_q2, 1'b0);
    check("R9", "same.q1 init", s_q1, 1'b1);
    check("R6", "same.q2 init", s_q2, 1'b0);
    check("R6", "pipe.q1 init", p_q1, 1'b0);
    check("R9", "pipe.q2 init", p_q2, 1'b1);
    check("R6", "sync.q1 init", y_q1, 1'b1);
    check("R6", "sync.q2 init", y_q2, 1'b1);
    sr = 1'b0; ce = 1'b1;
    same_pb = 1'b0;
    pipe_pa = 1'b0; pipe_pb = 1'b1;
    sync_pa = 1'b1; sync_pb = 1'b1;
  endtask

  task automatic t_alternating();
    for (int i = 0; i < 8; i++) run_cycle(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) run_cycle(1'b0, 1'b1);
    for (int i = 0; i < 8; i++) run_cycle(i[0], i[0]);
  endtask

  task automatic t_lfsr();
    logic [7:0] lfsr = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      run_cycle(lfsr[0], lfsr[3]);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
  endtask

  task automatic t_ce_hold();
    logic h1, h2, hs1, hs2, hp1, hp2, hy1, hy2;
    run_cycle(1'b1, 1'b0);
    h1 = o_q1; h2 = o_q2; hs1 = s_q1; hs2 = s_q2;
    hp1 = p_q1; hp2 = p_q2; hy1 = y_q1; hy2 = y_q2;
    ce = 1'b0;
    for (int i = 0; i < 3; i++) begin
      din = ~h1;
      @(posedge clk); #1 din = ~h2;
      @(negedge clk); #1;
      check("R5", "uut.q1 hold", o_q1, h1);
      check("R5", "uut.q2 hold", o_q2, h2);
      check("R5", "same.q1 hold", s_q1, hs1);
      check("R5", "same.q2 hold", s_q2, hs2);
      check("R5", "pipe.q1 hold", p_q1, hp1);
      check("R5", "pipe.q2 hold", p_q2, hp2);
      check("R5", "sync.q1 hold", y_q1, hy1);
      check("R5", "sync.q2 hold", y_q2, hy2);
    end
    ce = 1'b1;
    // Resumes from the held state (model untouched during the hold)
    run_cycle(1'b0, 1'b1);
    run_cycle(1'b1, 1'b1);
  endtask

  task automatic t_async_pulse();
    logic y1, y2;
    run_cycle(1'b1, 1'b1);
    run_cycle(1'b1, 1'b1);
    y1 = y_q1; y2 = y_q2;
    ce = 1'b0;                 // reset must win over a low enable
    sr = 1'b1; #0.5 sr = 1'b0; #0.2;
    check("R7", "uut.q1 async", o_q1, 1'b0);
    check("R7", "uut.q2 async", o_q2, 1'b0);
    check("R9", "same.q1 async", s_q1, 1'b1);
    check("R7", "same.q2 async", s_q2, 1'b0);
    check("R7", "pipe.q1 async", p_q1, 1'b0);
    check("R9", "pipe.q2 async", p_q2, 1'b1);
    check("R8", "sync.q1 untouched", y_q1, y1);
    check("R8", "sync.q2 untouched", y_q2, y2);
    ce = 1'b1;
    same_pb = 1'b0;
    pipe_pa = 1'b0; pipe_pb = 1'b1;
    for (int i = 0; i < 4; i++) run_cycle(i[1], ~i[0]);
  endtask

  task automatic t_sync_edge();
    logic y1, y2;
    run_cycle(1'b0, 1'b0);
    y1 = y_q1; y2 = y_q2;
    din = 1'b0;
    sr = 1'b1; #0.5;
    check("R8", "sync.q1 before edge", y_q1, y1);
    check("R8", "sync.q2 before edge", y_q2, y2);
    check("R7", "pipe.q2 immediate", p_q2, 1'b1);
    @(posedge clk); #1;
    sr = 1'b0; din = 1'b0;
    check("R8", "sync.q1 at edge", y_q1, 1'b1);
    check("R8", "sync.q2 at edge", y_q2, 1'b1);
    @(negedge clk); #1;
    check("R2", "uut.q2 after reset", o_q2, 1'b0);
    check("R8", "sync.q2 holds reset", y_q2, 1'b1);
    // Rising stages were reset; falling stage captured 0 after release
    same_pb = 1'b0;
    pipe_pa = 1'b0; pipe_pb = 1'b0;
    sync_pa = 1'b1; sync_pb = 1'b0;
    for (int i = 0; i < 6; i++) run_cycle(~i[0], i[1]);
  endtask

  initial begin
    t_reset_state();
    t_alternating();
    t_ce_hold();
    t_lfsr();
    t_async_pulse();
    t_sync_edge();
    t_alternating();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule